// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a reloadable down-counter of `CNT_W` bits (24 by default). A small synchronous register port exposes three registers: control/status, reload value and current value. When enabled, the counter decrements either on every core clock cycle or only on cycles where an external reference tick pulse is high. When it reaches zero, the next tick loads it from the reload register. A sticky flag records each hardware count from 1 to 0. If the interrupt enable is set, that event also produces a one-cycle interrupt request pulse.

Software programs a period of N ticks by writing N-1 as the reload value. It then writes the current-value register, which zeroes the counter and clears the flag, and sets the enable bit. A status read returns the flag and clears it. When the block is built without an external reference (`HAS_EXT_REF = 0`), the clock-select bit reads as 1, ignores writes, and the core clock drives the count.

A three-state machine tracks the counter:
- States: `ST_OFF` (disabled), `ST_LOAD` (counter at zero, the next tick loads the reload value) and `ST_DOWN` (counter non-zero, each tick decrements it).
- Transitions:
  - enable: `ST_OFF` to `ST_LOAD` or `ST_DOWN`, depending on whether the counter is zero.
  - disable: any state to `ST_OFF`.
  - reload: `ST_LOAD` to `ST_DOWN` on a tick with a non-zero reload value.
  - wrap: `ST_DOWN` to `ST_LOAD` on a tick at count 1.
  - clear: a current-value write goes to `ST_LOAD`, or to `ST_OFF` if the block is disabled.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current registers all read 0, except that control bit 2 reads 1 when `HAS_EXT_REF = 0`.
- R2: Register map: control/status at 0x10, reload at 0x14 (bits 23:0), current value at 0x18 (bits 23:0), and any other address reads 0. Control bits: bit 0 enable, bit 1 interrupt enable, bit 2 clock select (1 = core clock, 0 = external tick), bit 16 count flag (read-only). Unused bits read 0. Read data is registered and appears one cycle after the read strobe.
- R3: While enabled with core clock selected, the counter moves one step every cycle, so a reload value of N-1 gives interrupt pulses exactly N cycles apart.
- R4: A tick taken while the counter is 0 loads the reload value and does not set the flag.
- R5: A counting transition from 1 to 0 sets the count flag.
- R6: A control/status read returns the flag and then clears it. If a 1-to-0 transition occurs in the same cycle as the read, the flag stays set.
- R7: Any write to the current-value register zeroes the counter and clears the flag, and it produces no interrupt pulse.
- R8: With the interrupt enable set, each 1-to-0 count transition gives an `irq` pulse exactly one cycle long. With the interrupt enable clear, no pulse occurs.
- R9: With clock select 0, the counter changes only on cycles where `ext_tick` is high.
- R10: A reload value of 0 keeps the counter at 0 and produces no pulses.
- R11: Clearing the enable bit freezes the counter value.
- R12: With `HAS_EXT_REF = 0`, the clock-select bit reads 1 regardless of writes, and counting uses the core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| ext_tick | input | 1 | One-cycle reference tick, synchronous to `clk` |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong state in the counter or the state machine shows up at `irq`: the pulse spacing drifts from N cycles within one period, or a pulse appears during a software clear or with a zero reload value. A wrong flag shows up on the very next status read, as bit 16 with the wrong value or as a set flag that survives the read. Wrong clock gating shows up within a few cycles, as a current-value readback that changes without external ticks or stays frozen while ticks arrive.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int OFF_CTL  = 'h10;
    localparam int OFF_RLD  = 'h14;
    localparam int OFF_CUR  = 'h18;
    localparam int B_EN     = 0;
    localparam int B_INTEN  = 1;
    localparam int B_CLKSEL = 2;
    localparam int B_FLAG   = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_DOWN = 2'd2
    } tick_state_e;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 24,
    parameter bit HAS_EXT_REF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cur,
    input  logic              cnt_flag,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              inten,
    output logic              use_core,
    output logic [CNT_W-1:0]  reload,
    output logic              wr_cur,
    output logic              rd_stat
);
    logic              sel_ctl, sel_rld, sel_cur;
    logic [DATA_W-1:0] rd_mux;

    assign sel_ctl = (addr == ADDR_W'(OFF_CTL));
    assign sel_rld = (addr == ADDR_W'(OFF_RLD));
    assign sel_cur = (addr == ADDR_W'(OFF_CUR));
    assign wr_cur  = wr_en && sel_cur;
    assign rd_stat = rd_en && sel_ctl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            inten  <= 1'b0;
            reload <= '0;
        end else if (wr_en) begin
            if (sel_ctl) begin
                en    <= wdata[B_EN];
                inten <= wdata[B_INTEN];
            end
            if (sel_rld) reload <= wdata[CNT_W-1:0];
        end
    end

    generate
        if (HAS_EXT_REF) begin : g_sel
            logic sel_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                sel_q <= 1'b0;
                else if (wr_en && sel_ctl) sel_q <= wdata[B_CLKSEL];
            end
            assign use_core = sel_q;
        end else begin : g_nosel
            assign use_core = 1'b1;
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (sel_ctl) begin
            rd_mux[B_EN]     = en;
            rd_mux[B_INTEN]  = inten;
            rd_mux[B_CLKSEL] = use_core;
            rd_mux[B_FLAG]   = cnt_flag;
        end else if (sel_rld) begin
            rd_mux[CNT_W-1:0] = reload;
        end else if (sel_cur) begin
            rd_mux[CNT_W-1:0] = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R2: reload and current readbacks never carry bits above the counter width
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel_ctl) |=> (rdata[DATA_W-1:CNT_W] == '0));
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inten,
    input  logic             use_core,
    input  logic             ext_tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr_cur,
    input  logic             rd_stat,
    output logic [CNT_W-1:0] cur,
    output logic             cnt_flag,
    output logic             irq
);
    tick_state_e state, nxt;
    logic        tick, at_one, wrap;

    assign tick   = en && (state != ST_OFF) && (use_core || ext_tick);
    assign at_one = (cur == CNT_W'(1));
    assign wrap   = tick && (state == ST_DOWN) && at_one && !wr_cur;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  if (en) nxt = (cur == '0) ? ST_LOAD : ST_DOWN;
            ST_LOAD: if (!en) nxt = ST_OFF;
                     else if (tick && reload != '0) nxt = ST_DOWN;
            ST_DOWN: if (!en) nxt = ST_OFF;
                     else if (tick && at_one) nxt = ST_LOAD;
            default: nxt = ST_OFF;
        endcase
        if (wr_cur) nxt = en ? ST_LOAD : ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            cnt_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= wrap && inten;
            if (wr_cur)                       cur <= '0;
            else if (tick && state == ST_LOAD) cur <= reload;
            else if (tick && state == ST_DOWN) cur <= cur - CNT_W'(1);
            if (wr_cur)       cnt_flag <= 1'b0;
            else if (wrap)    cnt_flag <= 1'b1;
            else if (rd_stat) cnt_flag <= 1'b0;
        end
    end

    // R4: the load state is only ever occupied with the counter at zero
    a_r4_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (cur == '0));
    // R3: the down state never holds a zero count
    a_r3_down_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |-> (cur != '0));
    // R8: a request pulse lasts one cycle and coincides with a set flag at zero
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cur == '0 && cnt_flag) ##1 !irq);
    // R7: a software clear leaves zero, no flag and no request
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> (cur == '0 && !cnt_flag && !irq));
    // R11: a disabled counter keeps its value unless software clears it
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && state == ST_OFF && !wr_cur) |=> $stable(cur));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 24,
    parameter bit HAS_EXT_REF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    input  logic              ext_tick,
    output logic              irq
);
    logic             en, inten, use_core, wr_cur, rd_stat, cnt_flag;
    logic [CNT_W-1:0] reload, cur;

    tick_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HAS_EXT_REF(HAS_EXT_REF)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .cur(cur), .cnt_flag(cnt_flag), .rdata(rdata), .en(en),
        .inten(inten), .use_core(use_core), .reload(reload), .wr_cur(wr_cur),
        .rd_stat(rd_stat)
    );

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .inten(inten), .use_core(use_core),
        .ext_tick(ext_tick), .reload(reload), .wr_cur(wr_cur), .rd_stat(rd_stat),
        .cur(cur), .cnt_flag(cnt_flag), .irq(irq)
    );
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        ext_tick = 1'b0;
    logic [31:0] rdata, rdata1;
    logic        irq, irq1;
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    tick_timer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                   .rd_en(rd_en), .rdata(rdata), .ext_tick(ext_tick), .irq(irq));
    tick_timer #(.HAS_EXT_REF(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                   .wdata(wdata), .rd_en(rd_en), .rdata(rdata1), .ext_tick(ext_tick), .irq(irq1));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d0 = rdata; d1 = rdata1;
    endtask

    task automatic pulse_ext(output logic seen);
        @(negedge clk); ext_tick = 1'b1;
        @(negedge clk); ext_tick = 1'b0; seen = irq;
    endtask

    task automatic t_reset_map();
        logic [31:0] a, b;
        rd(8'h10, a, b); chk("R1 ctrl", a, 32'h0); chk("R1 ctrl no-ext", b, 32'h4);
        rd(8'h14, a, b); chk("R1 reload", a, 32'h0);
        rd(8'h18, a, b); chk("R1 current", a, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, a, b); chk("R2 reload width", a, 32'h00FF_FFFF);
        rd(8'h1C, a, b); chk("R2 unmapped", a, 32'h0);
    endtask

    task automatic t_period();
        logic [31:0] a, b;
        int n;
        wr(8'h14, 32'd4); wr(8'h18, 32'h0); wr(8'h10, 32'h7);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 30);
        chk("R8 first pulse", irq, 1'b1);
        n = 0;
        do begin @(negedge clk); n++; if (n == 1) chk("R8 one cycle", irq, 1'b0); end
        while (!irq && n < 30);
        chk("R3 period", n, 5);
        wr(8'h10, 32'h6);
        rd(8'h10, a, b); chk("R5 flag set", a, 32'h0001_0006);
        rd(8'h10, a, b); chk("R6 flag cleared by read", a, 32'h6);
        rd(8'h18, a, b);
        repeat (5) @(negedge clk);
        rd(8'h18, b, b); chk("R11 frozen", b, a);
    endtask

    task automatic t_no_inten();
        logic [31:0] a, b;
        int seen;
        wr(8'h10, 32'h5);
        seen = 0;
        repeat (15) begin @(negedge clk); if (irq) seen++; end
        wr(8'h10, 32'h4);
        chk("R8 no pulse when disabled", seen, 0);
        rd(8'h10, a, b); chk("R5 flag without irq", a, 32'h0001_0004);
    endtask

    task automatic t_zero_reload();
        logic [31:0] a, b;
        int seen;
        wr(8'h14, 32'h0); wr(8'h18, 32'h0); rd(8'h10, a, b);
        wr(8'h10, 32'h7);
        seen = 0;
        repeat (20) begin @(negedge clk); if (irq) seen++; end
        chk("R10 no pulses", seen, 0);
        rd(8'h18, a, b); chk("R10 held at zero", a, 32'h0);
        rd(8'h10, a, b); chk("R10 no flag", a, 32'h7);
    endtask

    task automatic t_ext_clear();
        logic [31:0] a, b;
        logic s;
        wr(8'h10, 32'h0); wr(8'h14, 32'd1); wr(8'h18, 32'h0); rd(8'h10, a, b);
        wr(8'h10, 32'h3);
        repeat (10) @(negedge clk);
        rd(8'h18, a, b); chk("R9 no tick no count", a, 32'h0);
        pulse_ext(s); chk("R4 load no pulse", s, 1'b0);
        rd(8'h10, a, b); chk("R4 load no flag", a, 32'h3);
        rd(8'h18, a, b); chk("R9 tick loads", a, 32'h1);
        pulse_ext(s); chk("R9 tick reaches zero", s, 1'b1);
        pulse_ext(s);
        wr(8'h18, 32'hDEAD);
        chk("R7 no pulse on clear", irq, 1'b0);
        rd(8'h10, a, b); chk("R7 flag cleared", a, 32'h3);
        rd(8'h18, a, b); chk("R7 counter zeroed", a, 32'h0);
        pulse_ext(s);
        @(negedge clk); addr = 8'h10; rd_en = 1'b1; ext_tick = 1'b1;
        @(negedge clk); rd_en = 1'b0; ext_tick = 1'b0;
        chk("R6 read same cycle old", rdata, 32'h3);
        chk("R8 pulse same cycle", irq, 1'b1);
        rd(8'h10, a, b); chk("R6 set wins", a, 32'h0001_0003);
        rd(8'h10, a, b); chk("R6 cleared after", a, 32'h3);
    endtask

    task automatic t_no_ext();
        logic [31:0] a, b;
        int s0, s1;
        wr(8'h10, 32'h0); wr(8'h14, 32'd2); wr(8'h18, 32'h0); rd(8'h10, a, b);
        wr(8'h10, 32'h3);
        rd(8'h10, a, b);
        chk("R12 select forced", b, 32'h7);
        chk("R9 select kept", a, 32'h3);
        s0 = 0; s1 = 0;
        repeat (12) begin @(negedge clk); if (irq) s0++; if (irq1) s1++; end
        chk("R12 core clock counts", (s1 > 0), 1'b1);
        chk("R9 ext idle no count", s0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog got=%0d exp<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_map();
        t_period();
        t_no_inten();
        t_zero_reload();
        t_ext_clear();
        t_no_ext();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule